// File: doc/BRIEF.md
# TPM Command-Response Buffer Register Interface

This block is the memory-mapped front of a TPM 2.0 command/response buffer interface. A host bus sees a 4 KiB window. The low 128 bytes are a 32-bit register file. It holds locality state, interface identity, the idle/ready request, status, start and cancel doorbells, and the fixed size and address of the data buffer. The rest of the window is a byte-writable data buffer. That single buffer holds both the command and the response.

Software writes a command into the buffer and rings the start doorbell. The block then raises a single-cycle start pulse towards the TPM backend. The pulse carries the command length, which the block takes from the big-endian length field in the command header and clamps to the usable buffer size. The start bit stays busy until the backend reports completion. Completion can carry an error flag, which latches a fatal status bit. While the start bit is busy, a write to the cancel doorbell is forwarded as a cancel pulse. Reads of any width return the aligned word shifted down by the byte offset.

Top module: `crb_if`

## Requirements
- R1: After reset, the locality state (0x00), locality status (0x0C), control status (0x44) and start (0x4C) registers all read 0.
- R2: The identity register at 0x30 reads 0x00025811. This value holds type 1 in [3:0], version 1 in [7:4], transfer-size 3 in [12:11], buffer interface 1 in bit 14, selector 1 in [18:17], and zeros elsewhere. The register at 0x34 reads the VENDOR_ID parameter in [15:0] and zero above it.
- R3: The command size (0x58) and response size (0x64) registers both read WIN_BYTES−0x80, which is 0xF80 by default. The command address (0x5C) and response address (0x68) registers both read BASE_ADDR+0x80.
- R4: A register write of exactly 1 to 0x4C, made while start bit 0 is clear, sets that bit and gives one be_start pulse on the next cycle. A write of 1 while the bit is set produces no pulse, and so does any other value.
- R5: be_done clears start bit 0. be_done together with be_done_err sets bit 0 of 0x44, and that bit stays set until reset.
- R6: A write of exactly 1 to 0x48 gives one be_cancel pulse only while start bit 0 is set. At any other time the write has no effect.
- R7: A write of 1 to 0x40 clears the idle bit, which is bit 1 of 0x44. A write of 2 sets it. Other values are ignored.
- R8: A write of 1 to 0x08 sets bit 0 of 0x0C and bits 1 and 7 of 0x00. Writes of 2 or 8 change nothing. Bit 1 of 0x0C always reads 0.
- R9: A read returns on bus_rdata, with bus_rvalid high, two clock cycles after the request. The value is the aligned 32-bit word shifted right by 8×bus_addr[1:0].
- R10: be_cmd_len equals the smaller of two values: the big-endian 32-bit value in buffer bytes 2..5 (byte 2 most significant), and min(BACKEND_BYTES, WIN_BYTES−0x80).
- R11: Addresses at 0x80 and above access the data buffer. Writes update only the byte lanes enabled in bus_be, and reads return the stored bytes.
- R12: Writes to read-only or unlisted register offsets (for example 0x30, 0x44 and 0x58) change no register. Register writes use the whole bus_wdata word and ignore bus_be.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wdata | input | 32 | Write data, little-endian lanes |
| bus_be | input | 4 | Byte-lane enables for buffer writes |
| bus_rdata | output | 32 | Read data, two cycles after the request |
| bus_rvalid | output | 1 | bus_rdata is valid |
| be_start | output | 1 | One-cycle request to the backend |
| be_cmd_len | output | LEN_W | Clamped command length given with be_start |
| be_cancel | output | 1 | One-cycle cancel to the backend |
| be_done | input | 1 | Backend completion |
| be_done_err | input | 1 | Completion carries a fatal error |

## Verification
The hardest state to reach is the window in which a command is outstanding. Cancel is honoured and a repeated start is refused only inside this window, and it ends only when the backend completes. The bench opens the window by writing a command header and ringing the start doorbell. It then holds be_done low while it repeats the start and issues a cancel. Completion is driven afterwards, and the cancel is repeated to confirm it is dropped. A header whose length exceeds the buffer is placed with partial byte-lane writes, so that the clamp is reached through the same snooped bytes.

// File: rtl/crb_pkg.sv
package crb_pkg;
  typedef logic [7:0] crb_ofs_t;

  localparam crb_ofs_t OFS_LOC_STATE = 8'h00;
  localparam crb_ofs_t OFS_LOC_CTRL  = 8'h08;
  localparam crb_ofs_t OFS_LOC_STS   = 8'h0C;
  localparam crb_ofs_t OFS_IDENT     = 8'h30;
  localparam crb_ofs_t OFS_IDENT2    = 8'h34;
  localparam crb_ofs_t OFS_CTRL_REQ  = 8'h40;
  localparam crb_ofs_t OFS_CTRL_STS  = 8'h44;
  localparam crb_ofs_t OFS_CANCEL    = 8'h48;
  localparam crb_ofs_t OFS_START     = 8'h4C;
  localparam crb_ofs_t OFS_CMD_SIZE  = 8'h58;
  localparam crb_ofs_t OFS_CMD_ADDR  = 8'h5C;
  localparam crb_ofs_t OFS_RSP_SIZE  = 8'h64;
  localparam crb_ofs_t OFS_RSP_ADDR  = 8'h68;

  // identity word assembled from its fields
  function automatic logic [31:0] ident_word();
    logic [31:0] w;
    w        = '0;
    w[3:0]   = 4'd1;  // interface type: buffer active
    w[7:4]   = 4'd1;  // interface version
    w[12:11] = 2'd3;  // transfer size up to 64 bytes
    w[14]    = 1'b1;  // buffer interface supported
    w[18:17] = 2'd1;  // selector: buffer interface
    return w;
  endfunction
endpackage

// File: rtl/crb_databuf.sv
module crb_databuf #(
  parameter int DEPTH = 992,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic             re,
  input  logic [3:0]       be,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int l = 0; l < 4; l++) begin
      if (we && be[l]) mem[idx][8*l +: 8] <= wdata[8*l +: 8];
    end
    if (re) rdata <= mem[idx];
  end
endmodule

// File: rtl/crb_hdr_len.sv
module crb_hdr_len #(
  parameter int IDX_W = 10,
  parameter int LEN_W = 32,
  parameter int unsigned LIMIT = 3968
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [3:0]       be,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  output logic [LEN_W-1:0] len
);
  // big-endian length in buffer bytes 2..5, snooped from writes
  logic [31:0] hdr;

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr <= '0;
    end else if (we && idx == IDX_W'(0)) begin
      if (be[2]) hdr[31:24] <= wdata[23:16];
      if (be[3]) hdr[23:16] <= wdata[31:24];
    end else if (we && idx == IDX_W'(1)) begin
      if (be[0]) hdr[15:8] <= wdata[7:0];
      if (be[1]) hdr[7:0]  <= wdata[15:8];
    end
  end

  always_comb begin
    if (hdr > 32'(LIMIT)) len = LEN_W'(LIMIT);
    else                  len = LEN_W'(hdr);
  end
endmodule

// File: rtl/crb_ctrl.sv
module crb_ctrl
  import crb_pkg::*;
#(
  parameter int LEN_W = 32,
  parameter int unsigned LIMIT = 3968
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  crb_ofs_t         wr_ofs,
  input  logic [31:0]      wr_data,
  input  logic [LEN_W-1:0] clamp_len,
  input  logic             done,
  input  logic             done_err,
  output logic             loc_assigned,
  output logic             reg_valid,
  output logic             granted,
  output logic             sts_err,
  output logic             sts_idle,
  output logic             busy,
  output logic             start_pulse,
  output logic [LEN_W-1:0] start_len,
  output logic             cancel_pulse
);
  logic is_one, req_hit, loc_hit, start_hit, cancel_hit;

  assign is_one     = (wr_data == 32'd1);
  assign req_hit    = wr_en && (wr_ofs == OFS_CTRL_REQ);
  assign loc_hit    = wr_en && (wr_ofs == OFS_LOC_CTRL) && is_one;
  assign start_hit  = wr_en && (wr_ofs == OFS_START) && is_one && !busy;
  assign cancel_hit = wr_en && (wr_ofs == OFS_CANCEL) && is_one && busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      loc_assigned <= 1'b0;
      reg_valid    <= 1'b0;
      granted      <= 1'b0;
      sts_err      <= 1'b0;
      sts_idle     <= 1'b0;
      busy         <= 1'b0;
      start_pulse  <= 1'b0;
      start_len    <= '0;
      cancel_pulse <= 1'b0;
    end else begin
      start_pulse  <= start_hit;
      cancel_pulse <= cancel_hit;
      if (start_hit) start_len <= clamp_len;
      if (busy) begin
        if (done) busy <= 1'b0;
      end else if (start_hit) begin
        busy <= 1'b1;
      end
      if (done && done_err) sts_err <= 1'b1;
      if (req_hit) begin
        if (wr_data == 32'd1)      sts_idle <= 1'b0;
        else if (wr_data == 32'd2) sts_idle <= 1'b1;
      end
      if (loc_hit) begin
        granted      <= 1'b1;
        loc_assigned <= 1'b1;
        reg_valid    <= 1'b1;
      end
    end
  end

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    busy |=> !start_pulse);  // R4
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (busy && done) |=> !busy);  // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    sts_err |=> sts_err);  // R5
  AST_CANCEL_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    cancel_pulse |-> $past(busy));  // R6
  AST_LEN_CLAMPED: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> (start_len <= LEN_W'(LIMIT)));  // R10
endmodule

// File: rtl/crb_if.sv
module crb_if
  import crb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WIN_BYTES = 4096,
  parameter int BUF_OFS = 128,
  parameter logic [31:0] BASE_ADDR = 32'hFED40000,
  parameter logic [15:0] VENDOR_ID = 16'h1014,
  parameter int BACKEND_BYTES = 4096,
  parameter int LEN_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_be,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              be_start,
  output logic [LEN_W-1:0]  be_cmd_len,
  output logic              be_cancel,
  input  logic              be_done,
  input  logic              be_done_err
);
  localparam int BUF_BYTES = WIN_BYTES - BUF_OFS;
  localparam int DEPTH     = BUF_BYTES / 4;
  localparam int IDX_W     = $clog2(DEPTH);
  localparam int unsigned LIMIT =
    (BACKEND_BYTES < BUF_BYTES) ? BACKEND_BYTES : BUF_BYTES;
  localparam logic [31:0] BUF_ADDR = BASE_ADDR + 32'(BUF_OFS);

  logic              in_buf;
  logic [ADDR_W-3:0] word_addr;
  logic [IDX_W-1:0]  widx;
  crb_ofs_t          reg_ofs;
  logic              buf_we, buf_re, reg_we;
  logic [31:0]       mem_q;
  logic [LEN_W-1:0]  clamp_len;

  logic loc_assigned, reg_valid, granted, sts_err, sts_idle, busy;

  assign in_buf    = (bus_addr >= ADDR_W'(BUF_OFS));
  assign word_addr = bus_addr[ADDR_W-1:2] - (ADDR_W-2)'(BUF_OFS / 4);
  assign widx      = IDX_W'(word_addr);
  assign reg_ofs   = {bus_addr[7:2], 2'b00};
  assign buf_we    = bus_valid && bus_write && in_buf;
  assign buf_re    = bus_valid && !bus_write && in_buf;
  assign reg_we    = bus_valid && bus_write && !in_buf;

  crb_databuf #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .we(buf_we), .re(buf_re), .be(bus_be),
    .idx(widx), .wdata(bus_wdata), .rdata(mem_q)
  );

  crb_hdr_len #(.IDX_W(IDX_W), .LEN_W(LEN_W), .LIMIT(LIMIT)) u_len (
    .clk(clk), .rst(rst), .we(buf_we), .be(bus_be),
    .idx(widx), .wdata(bus_wdata), .len(clamp_len)
  );

  crb_ctrl #(.LEN_W(LEN_W), .LIMIT(LIMIT)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(reg_we), .wr_ofs(reg_ofs),
    .wr_data(bus_wdata), .clamp_len(clamp_len),
    .done(be_done), .done_err(be_done_err),
    .loc_assigned(loc_assigned), .reg_valid(reg_valid),
    .granted(granted), .sts_err(sts_err), .sts_idle(sts_idle),
    .busy(busy), .start_pulse(be_start), .start_len(be_cmd_len),
    .cancel_pulse(be_cancel)
  );

  // register read mux
  logic [31:0] reg_word;
  always_comb begin
    case (reg_ofs)
      OFS_LOC_STATE: reg_word = {24'd0, reg_valid, 5'd0, loc_assigned, 1'b0};
      OFS_LOC_STS:   reg_word = {31'd0, granted};
      OFS_IDENT:     reg_word = ident_word();
      OFS_IDENT2:    reg_word = {16'd0, VENDOR_ID};
      OFS_CTRL_STS:  reg_word = {30'd0, sts_idle, sts_err};
      OFS_START:     reg_word = {31'd0, busy};
      OFS_CMD_SIZE,
      OFS_RSP_SIZE:  reg_word = 32'(BUF_BYTES);
      OFS_CMD_ADDR,
      OFS_RSP_ADDR:  reg_word = BUF_ADDR;
      default:       reg_word = 32'd0;
    endcase
  end

  // two-stage read path
  logic        rv1, sel_buf1;
  logic [1:0]  bofs1;
  logic [31:0] reg_q1, word1;

  always_ff @(posedge clk) begin
    if (rst) begin
      rv1        <= 1'b0;
      sel_buf1   <= 1'b0;
      bofs1      <= 2'd0;
      reg_q1     <= '0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      rv1        <= bus_valid && !bus_write;
      sel_buf1   <= in_buf;
      bofs1      <= bus_addr[1:0];
      reg_q1     <= reg_word;
      bus_rvalid <= rv1;
      if (rv1) bus_rdata <= word1 >> (8 * bofs1);
    end
  end

  assign word1 = sel_buf1 ? mem_q : reg_q1;

  AST_RVALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |=> ##1 bus_rvalid);  // R9
  AST_START_CANCEL_EXCL: assert property (@(posedge clk) disable iff (rst)
    be_start |-> !be_cancel);  // R6
endmodule

// File: tb/tb_crb_if.sv
`timescale 1ns/1ps
module tb_crb_if;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        be_start, be_cancel;
  logic [31:0] be_cmd_len;
  logic        be_done = 1'b0, be_done_err = 1'b0;

  int errors = 0, checks = 0;
  int n_start = 0, n_cancel = 0;
  logic [31:0] last_len = '0;

  always #10 clk = ~clk;

  crb_if dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .be_start(be_start), .be_cmd_len(be_cmd_len), .be_cancel(be_cancel),
    .be_done(be_done), .be_done_err(be_done_err)
  );

  always @(posedge clk) begin
    if (!rst) begin
      if (be_start) begin n_start++; last_len = be_cmd_len; end
      if (be_cancel) n_cancel++;
    end
  end

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    @(negedge clk);
    d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic rd_chk(input string rq, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d; logic v;
    rd(a, d, v);
    check({rq, " rvalid"}, {31'd0, v}, 32'd1);
    check(rq, d, exp);
  endtask

  task automatic done(input logic e);
    @(negedge clk);
    be_done = 1'b1; be_done_err = e;
    @(negedge clk);
    be_done = 1'b0; be_done_err = 1'b0;
  endtask

  // {req tag, write, addr, wdata, expected read}
  localparam int NV = 38;
  localparam logic [80:0] VEC [NV] = '{
    {4'd1, 1'b0, 12'h000, 32'h0, 32'h0},                // R1
    {4'd1, 1'b0, 12'h00C, 32'h0, 32'h0},                // R1
    {4'd1, 1'b0, 12'h044, 32'h0, 32'h0},                // R1
    {4'd1, 1'b0, 12'h04C, 32'h0, 32'h0},                // R1
    {4'd2, 1'b0, 12'h030, 32'h0, 32'h00025811},         // R2
    {4'd2, 1'b0, 12'h034, 32'h0, 32'h00001014},         // R2
    {4'd3, 1'b0, 12'h058, 32'h0, 32'h00000F80},         // R3
    {4'd3, 1'b0, 12'h064, 32'h0, 32'h00000F80},         // R3
    {4'd3, 1'b0, 12'h05C, 32'h0, 32'hFED40080},         // R3
    {4'd3, 1'b0, 12'h068, 32'h0, 32'hFED40080},         // R3
    {4'd9, 1'b0, 12'h031, 32'h0, 32'h00000258},         // R9
    {4'd9, 1'b0, 12'h032, 32'h0, 32'h00000002},         // R9
    {4'd9, 1'b0, 12'h033, 32'h0, 32'h00000000},         // R9
    {4'd9, 1'b0, 12'h05D, 32'h0, 32'h00FED400},         // R9
    {4'd7, 1'b1, 12'h040, 32'h2, 32'h0},                // R7 go idle
    {4'd7, 1'b0, 12'h044, 32'h0, 32'h2},
    {4'd7, 1'b1, 12'h040, 32'h5, 32'h0},                // R7 ignored
    {4'd7, 1'b0, 12'h044, 32'h0, 32'h2},
    {4'd7, 1'b1, 12'h040, 32'h1, 32'h0},                // R7 ready
    {4'd7, 1'b0, 12'h044, 32'h0, 32'h0},
    {4'd8, 1'b1, 12'h008, 32'h2, 32'h0},                // R8 relinquish
    {4'd8, 1'b1, 12'h008, 32'h8, 32'h0},                // R8 reset-est
    {4'd8, 1'b0, 12'h00C, 32'h0, 32'h0},
    {4'd8, 1'b0, 12'h000, 32'h0, 32'h0},
    {4'd8, 1'b1, 12'h008, 32'h1, 32'h0},                // R8 request
    {4'd8, 1'b0, 12'h00C, 32'h0, 32'h1},
    {4'd8, 1'b0, 12'h000, 32'h0, 32'h82},
    {4'd12, 1'b1, 12'h030, 32'h0, 32'h0},               // R12
    {4'd12, 1'b0, 12'h030, 32'h0, 32'h00025811},
    {4'd12, 1'b1, 12'h058, 32'h0, 32'h0},               // R12
    {4'd12, 1'b0, 12'h058, 32'h0, 32'h00000F80},
    {4'd12, 1'b1, 12'h044, 32'h3, 32'h0},               // R12
    {4'd12, 1'b0, 12'h044, 32'h0, 32'h0},
    {4'd4, 1'b1, 12'h04C, 32'h3, 32'h0},                // R4 non-one value
    {4'd4, 1'b0, 12'h04C, 32'h0, 32'h0},
    {4'd11, 1'b1, 12'h080, 32'hA5A5A5A5, 32'h0},        // R11
    {4'd11, 1'b0, 12'h080, 32'h0, 32'hA5A5A5A5},
    {4'd11, 1'b0, 12'h081, 32'h0, 32'h00A5A5A5}
  };

  initial begin : watchdog
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) wr(VEC[i][75:64], VEC[i][63:32], 4'hF);
      else rd_chk($sformatf("R%0d", VEC[i][80:77]), VEC[i][75:64], VEC[i][31:0]);
    end
    check("R4 no start from value 3", n_start, 0);

    // R10 header length 12, then R4 start
    wr(12'h080, 32'h00000180, 4'hF);
    wr(12'h084, 32'h00000C00, 4'hF);
    wr(12'h04C, 32'h1, 4'hF);
    repeat (2) @(negedge clk);
    check("R4 one start", n_start, 1);
    check("R10 length", last_len, 32'd12);
    rd_chk("R4 busy", 12'h04C, 32'h1);
    wr(12'h04C, 32'h1, 4'hF);
    repeat (2) @(negedge clk);
    check("R4 restart refused", n_start, 1);
    wr(12'h048, 32'h1, 4'hF);
    repeat (2) @(negedge clk);
    check("R6 cancel while busy", n_cancel, 1);
    done(1'b0);
    rd_chk("R5 cleared", 12'h04C, 32'h0);
    rd_chk("R5 no error", 12'h044, 32'h0);
    wr(12'h048, 32'h1, 4'hF);
    repeat (2) @(negedge clk);
    check("R6 cancel idle ignored", n_cancel, 1);

    // R10 clamp via partial lanes: length 0x2000 > 0xF80
    wr(12'h080, 32'h00000000, 4'b1100);
    wr(12'h084, 32'h00000020, 4'b0011);
    rd_chk("R11 lanes kept", 12'h080, 32'h00000180);
    wr(12'h04C, 32'h1, 4'hF);
    repeat (2) @(negedge clk);
    check("R4 second start", n_start, 2);
    check("R10 clamp", last_len, 32'h00000F80);
    done(1'b1);
    rd_chk("R5 fatal bit", 12'h044, 32'h1);
    rd_chk("R5 start cleared", 12'h04C, 32'h0);
    wr(12'h040, 32'h2, 4'hF);
    rd_chk("R5 error sticky", 12'h044, 32'h3);

    // R11 byte-lane write
    wr(12'h088, 32'h11223344, 4'hF);
    wr(12'h088, 32'hFFFFFFFF, 4'b0100);
    rd_chk("R11 partial write", 12'h088, 32'h11FF3344);

    // R1 reset clears state
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    rd_chk("R1 status after reset", 12'h044, 32'h0);
    rd_chk("R1 locality after reset", 12'h000, 32'h0);
    rd_chk("R1 granted after reset", 12'h00C, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule